// File: doc/BRIEF.md
# Segmented Sample Capture Buffer

This block records a probe word into an on-chip buffer when a capture is armed. The probe word is a 16-bit data value joined with an 8-bit counter value. Each capture fills the whole buffer, which is 1024 entries by default. A single pulse on `arm` starts a capture, and the mode and window count are latched on that pulse. In immediate mode, recording begins on the cycle after the arm pulse. In triggered mode, the block waits with `ready_to_capture` high until an external trigger unit sends a pulse. Sampling only happens in cycles where `clk_en` is high.

The buffer can be divided into 1, 2, 4 or 8 equal windows. The window depth is the buffer depth shifted right by the window-count selector. In triggered mode, each window starts on its own fresh trigger, and the trigger sample is stored at offset 0 of that window. In immediate mode, the windows fill one after another with no gap between them. Every stored entry carries two tags: the index of its window, and a flag that marks the trigger sample. When the last window is full, `done` is raised. After that, any entry can be read through a synchronous address/data port.

The controller is a four-state machine:
- IDLE: nothing has been armed since reset.
- WAIT: armed and waiting for a trigger.
- FILL: writing one sample per enabled cycle.
- DONE: capture complete.

The transitions are:
- IDLE or DONE go to FILL on arm in immediate mode, and to WAIT on arm in triggered mode.
- WAIT goes to FILL when an enabled trigger writes offset 0.
- FILL goes back to WAIT when a window ends in triggered mode.
- FILL stays in FILL when a window ends in immediate mode.
- FILL goes to DONE when the final buffer entry is written.

Top module: `seg_capture_buffer`

## Requirements
- R1: While reset is held, `ready_to_capture` and `done` are both 0.
- R2: With `trig_mode`=0, an arm pulse starts a capture. The first stored sample is the probe word present at the first enabled clock edge after the edge that saw `arm`. After that, DEPTH consecutive enabled-cycle samples are stored at addresses 0 to DEPTH-1.
- R3: With `trig_mode`=1, the block sits in WAIT with `ready_to_capture`=1. An enabled trigger stores the probe word of that same edge at offset 0 of the current window. Each stored entry reads back `rd_trig`=1 exactly at window offset 0.
- R4: `win_sel` value s (0 to 3) gives 2^s windows of DEPTH>>s entries each. Entry address a reads back `rd_win` = a / (DEPTH>>s).
- R5: Each triggered window needs a new trigger taken in WAIT. A trigger during FILL is ignored, and this includes a trigger in the cycle of a window's last write.
- R6: In a cycle with `clk_en`=0, no sample is stored, the write position does not advance, and a trigger is ignored.
- R7: After the last window fills, `done`=1 and `ready_to_capture`=0. `done` holds until the next arm pulse.
- R8: `rd_sample` is {probe_data[15:0] in bits 23:8, probe_count[7:0] in bits 7:0}. It appears one clock edge after `rd_addr` is presented, together with `rd_win` and `rd_trig`.
- R9: An arm pulse in WAIT or FILL is ignored, and the capture in progress continues unchanged.
- R10: In immediate mode with several windows, the windows fill back to back with no trigger. Each one is still tagged with its window index and has its offset-0 flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Sample enable; gates writes and triggers |
| arm | input | 1 | Capture request pulse, taken in IDLE or DONE |
| trig_mode | input | 1 | 0 = immediate, 1 = wait for trigger (latched at arm) |
| win_sel | input | SELW (2) | log2 of window count (latched at arm) |
| trig_in | input | 1 | Trigger pulse from the trigger unit |
| probe_data | input | DATA_W (16) | Data part of the probe word |
| probe_count | input | CNT_W (8) | Counter part of the probe word |
| ready_to_capture | output | 1 | Armed and waiting for a trigger |
| done | output | 1 | All windows full |
| rd_addr | input | AW (10) | Readout address |
| rd_sample | output | DATA_W+CNT_W (24) | Stored probe word |
| rd_win | output | MAX_WIN_LOG2 (3) | Window index of the entry |
| rd_trig | output | 1 | Entry is the trigger sample of its window |

## Verification
The sensitive collision is a trigger that arrives in the same cycle as the final write of a window. In that cycle the controller is still in FILL, so the trigger must be discarded, and the next window must wait for a later pulse. The bench counts the exact edge of the sixteenth write after a trigger and drives the trigger into that edge. It then checks that `ready_to_capture` is high and stays high for several cycles, and that the next window's stored data begins at the value present at the later trigger. A second overlap, an arm pulse and a trigger both landing during FILL, is judged by reading back every entry and comparing it with counter values computed arithmetically from the recorded trigger points.

// File: rtl/segcap_pkg.sv
package segcap_pkg;

    // Controller states of the capture sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

endpackage

// File: rtl/segcap_tagger.sv
// Derives the window index, first-of-window and last-of-window flags from
// the write address and the latched window-count selector.
module segcap_tagger #(
    parameter int AW    = 10,
    parameter int SELW  = 2,
    parameter int MAXL  = 3,
    localparam int WIN_W = MAXL,
    localparam int NCAND = MAXL + 1
) (
    input  logic [AW-1:0]    addr,
    input  logic [SELW-1:0]  sel,
    output logic [WIN_W-1:0] win_idx,
    output logic             win_first,
    output logic             win_end
);

    logic [WIN_W-1:0] idx_cand  [NCAND];
    logic [AW-1:0]    mask_cand [NCAND];
    logic [SELW-1:0]  sel_eff;
    logic [AW-1:0]    offs;

    // One candidate per legal window count: offset mask and index bits
    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        assign mask_cand[g] = {AW{1'b1}} >> g;
        if (g == 0) begin : g_single
            assign idx_cand[g] = '0;
        end else begin : g_multi
            assign idx_cand[g] = WIN_W'(addr[AW-1 -: g]);
        end
    end

    always_comb begin
        if (int'(sel) > MAXL) begin
            sel_eff = SELW'(MAXL);
        end else begin
            sel_eff = sel;
        end
        offs      = addr & mask_cand[sel_eff];
        win_idx   = idx_cand[sel_eff];
        win_first = (offs == '0);
        win_end   = (offs == mask_cand[sel_eff]);
    end

endmodule

// File: rtl/segcap_store.sv
// Sample memory: one write port, one synchronous read port.
module segcap_store #(
    parameter int DEPTH = 1024,
    parameter int EW    = 28,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/segcap_ctrl.sv
// Capture sequencer: arming, trigger wait, window fill, completion.
module segcap_ctrl
    import segcap_pkg::*;
#(
    parameter int AW   = 10,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic            arm,
    input  logic            trig_mode,
    input  logic [SELW-1:0] win_sel,
    input  logic            trig_in,
    input  logic            win_end,
    input  logic            win_first,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [SELW-1:0] sel_q,
    output logic            ready,
    output logic            done
);

    cap_state_e st_q, st_d;
    logic       mode_q;
    logic       accept_arm;
    logic       last_addr;

    assign accept_arm = arm && (st_q == ST_IDLE || st_q == ST_DONE);
    assign last_addr  = &wr_addr;
    assign wr_en      = clk_en && ((st_q == ST_FILL) || (st_q == ST_WAIT && trig_in));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    st_d = trig_mode ? ST_WAIT : ST_FILL;
                end
            end
            ST_WAIT: begin
                if (wr_en) begin
                    if (win_end) begin
                        st_d = last_addr ? ST_DONE : ST_WAIT;
                    end else begin
                        st_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (wr_en && win_end) begin
                    if (last_addr) begin
                        st_d = ST_DONE;
                    end else begin
                        st_d = mode_q ? ST_WAIT : ST_FILL;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Configuration latch and write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            sel_q   <= '0;
            wr_addr <= '0;
        end else if (accept_arm) begin
            mode_q  <= trig_mode;
            sel_q   <= win_sel;
            wr_addr <= '0;
        end else if (wr_en) begin
            wr_addr <= wr_addr + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ready = (st_q == ST_WAIT);
        done  = (st_q == ST_DONE);
    end

    p_ready_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));

    p_no_write_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !wr_en);

    p_ptr_hold_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && !clk_en) |=> $stable(wr_addr));

    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    p_trig_leaves_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && trig_in && clk_en && !win_end) |=> !ready);

    p_wait_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> win_first);

    p_arm_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && arm && !(wr_en && win_end)) |=> (st_q == ST_FILL));

endmodule

// File: rtl/seg_capture_buffer.sv
module seg_capture_buffer
    import segcap_pkg::*;
#(
    parameter int DEPTH        = 1024,
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 8,
    parameter int MAX_WIN_LOG2 = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int SELW = $clog2(MAX_WIN_LOG2 + 1),
    localparam int SW   = DATA_W + CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    arm,
    input  logic                    trig_mode,
    input  logic [SELW-1:0]         win_sel,
    input  logic                    trig_in,
    input  logic [DATA_W-1:0]       probe_data,
    input  logic [CNT_W-1:0]        probe_count,
    output logic                    ready_to_capture,
    output logic                    done,
    input  logic [AW-1:0]           rd_addr,
    output logic [SW-1:0]           rd_sample,
    output logic [MAX_WIN_LOG2-1:0] rd_win,
    output logic                    rd_trig
);

    localparam int EW = MAX_WIN_LOG2 + 1 + SW;

    logic                    wr_en;
    logic [AW-1:0]           wr_addr;
    logic [SELW-1:0]         sel_q;
    logic [MAX_WIN_LOG2-1:0] win_idx;
    logic                    win_first;
    logic                    win_end;
    logic [EW-1:0]           wdata;
    logic [EW-1:0]           rdata;

    segcap_ctrl #(
        .AW   (AW),
        .SELW (SELW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .arm       (arm),
        .trig_mode (trig_mode),
        .win_sel   (win_sel),
        .trig_in   (trig_in),
        .win_end   (win_end),
        .win_first (win_first),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .sel_q     (sel_q),
        .ready     (ready_to_capture),
        .done      (done)
    );

    segcap_tagger #(
        .AW   (AW),
        .SELW (SELW),
        .MAXL (MAX_WIN_LOG2)
    ) u_tag (
        .addr      (wr_addr),
        .sel       (sel_q),
        .win_idx   (win_idx),
        .win_first (win_first),
        .win_end   (win_end)
    );

    assign wdata = {win_idx, win_first, probe_data, probe_count};

    segcap_store #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    assign rd_sample = rdata[SW-1:0];
    assign rd_trig   = rdata[SW];
    assign rd_win    = rdata[EW-1 -: MAX_WIN_LOG2];

endmodule

// File: tb/seg_capture_buffer_test.sv
module seg_capture_buffer_test;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int SELW  = 2;
    localparam int WW    = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n     = 1'b0;
    logic            clk_en    = 1'b0;
    logic            arm       = 1'b0;
    logic            trig_mode = 1'b0;
    logic            trig_in   = 1'b0;
    logic [SELW-1:0] win_sel   = '0;
    logic [AW-1:0]   rd_addr   = '0;
    logic [15:0]     cur;
    logic            ready, done, rd_trig;
    logic [23:0]     rd_sample;
    logic [WW-1:0]   rd_win;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int base [8];

    seg_capture_buffer #(.DEPTH(DEPTH)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .clk_en           (clk_en),
        .arm              (arm),
        .trig_mode        (trig_mode),
        .win_sel          (win_sel),
        .trig_in          (trig_in),
        .probe_data       (cur ^ 16'hC3A5),
        .probe_count      (cur[7:0]),
        .ready_to_capture (ready),
        .done             (done),
        .rd_addr          (rd_addr),
        .rd_sample        (rd_sample),
        .rd_win           (rd_win),
        .rd_trig          (rd_trig)
    );

    // Probe source: advances only on enabled edges
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) cur <= 16'h0100;
        else if (clk_en) cur <= cur + 16'd1;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(negedge clk) begin
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start(input logic mode, input logic [SELW-1:0] ws, output logic [15:0] first);
        @(negedge clk);
        clk_en = 1'b1; trig_mode = mode; win_sel = ws; arm = 1'b1; first = cur;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic wait_ready();
        int n;
        n = 0;
        while (!ready && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic fire(output logic [15:0] v);
        wait_ready();
        clk_en = 1'b1; trig_in = 1'b1; v = cur;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic verify(input int ws, input string tag);
        int wd, w, j;
        logic [15:0] e;
        wd = DEPTH >> ws;
        for (int i = 0; i < DEPTH; i++) begin
            w = i / wd;
            j = i % wd;
            e = 16'(base[w] + j);
            rd_addr = AW'(i);
            @(negedge clk);
            chk(tag, "R8 stored sample", rd_sample, {e ^ 16'hC3A5, e[7:0]});
            chk("R4", "window tag", rd_win, w);
            chk("R3", "trigger-position tag", rd_trig, (j == 0));
        end
    endtask

    initial begin
        logic [15:0] f, v;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", ready, 0);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", ready, 0);

        // Immediate, one window
        start(1'b0, 2'd0, f);
        base[0] = int'(f) + 1;
        wait_done();
        chk("R7", "done after immediate", done, 1);
        chk("R7", "ready after immediate", ready, 0);
        verify(0, "R2");
        chk("R7", "done held", done, 1);

        // Immediate, two windows back to back, gated enable
        start(1'b0, 2'd1, f);
        base[0] = int'(f) + 1;
        base[1] = base[0] + 32;
        for (int k = 0; k < 400 && !done; k++) begin
            clk_en = (k % 3) != 0;
            @(negedge clk);
        end
        clk_en = 1'b1;
        chk("R7", "done after gated immediate", done, 1);
        verify(1, "R10");

        // Triggered, four windows
        start(1'b1, 2'd2, f);
        chk("R3", "ready while waiting", ready, 1);
        clk_en = 1'b0; trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; clk_en = 1'b1;
        chk("R6", "gated trigger ignored", ready, 1);
        fire(v); base[0] = int'(v);
        repeat (4) @(negedge clk);
        trig_in = 1'b1; arm = 1'b1;
        @(negedge clk);
        trig_in = 1'b0; arm = 1'b0;
        chk("R9", "arm in fill ignored", ready, 0);
        wait_ready();
        repeat (3) @(negedge clk);
        chk("R5", "waits for new trigger", ready, 1);
        fire(v); base[1] = int'(v);
        repeat (14) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk("R5", "last-write trigger ignored", ready, 1);
        repeat (3) @(negedge clk);
        chk("R5", "still waiting", ready, 1);
        fire(v); base[2] = int'(v);
        fire(v); base[3] = int'(v);
        wait_done();
        chk("R7", "done after triggered", done, 1);
        verify(2, "R5");

        // Triggered, eight windows with varied gaps
        start(1'b1, 2'd3, f);
        for (int w = 0; w < 8; w++) begin
            wait_ready();
            repeat (w) @(negedge clk);
            fire(v); base[w] = int'(v);
        end
        wait_done();
        chk("R7", "done after eight windows", done, 1);
        chk("R7", "ready low when done", ready, 0);
        verify(3, "R3");

        summary();
        $finish;
    end

endmodule